// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter with Double-Buffered Catch-All

This block decides where a received CAN frame goes once its identifier, format (11-bit standard or 29-bit extended) and type (data or remote) are known. It compares the frame against a bank of regular message objects. Each object holds a reference identifier, a format bit, a direction bit and a valid flag. The comparison uses one global mask per format. The lowest-numbered matching object owns the frame. Its direction and the frame type then decide the result: the frame is stored, it raises an answer request, or it is ignored.

A frame that no valid regular object matches falls through to a receive-only catch-all object. That object sits at index `NOBJ`. Its effective mask is the format's global mask ANDed with its own mask, and the masked identifier is compared against its own pattern. A type selector makes the catch-all take either data frames or remote frames, never both. It has two buffers. When both buffers are occupied, a new frame overwrites the more recently filled one and a message-lost flag is raised. Receivers free the buffers one at a time.

A small state machine sequences each decision. The states are ST_IDLE, ST_EVAL, ST_OBJ_HIT, ST_CA_STORE and ST_NO_HIT.
- ST_IDLE to ST_EVAL when a frame is offered. The identifier, format and type are captured on this transition.
- ST_EVAL to ST_OBJ_HIT when any regular object matches.
- ST_EVAL to ST_CA_STORE when no regular object matches but the catch-all accepts the frame.
- ST_EVAL to ST_NO_HIT otherwise.
- Each of the three result states returns to ST_IDLE after one cycle.

Top module: `can_acc_filter`

## Requirements
- R1: A regular object matches only if the frame format equals the object's format bit and every identifier bit under a mask 1 is equal. Mask 0 bits are don't-care. Standard frames use the 11-bit standard mask on identifier bits [10:0]. Extended frames use the 29-bit extended mask on bits [28:0].
- R2: An object whose `obj_val` bit is 0 never matches, so a lower-priority object can win instead.
- R3: When several valid regular objects match, the lowest index wins, even if that object then ignores the frame.
- R4: A receive object (`obj_dir` bit 0) winning with a data frame gives `store_stb`=1 and its index on `win_idx`. Winning with a remote frame gives neither strobe.
- R5: A transmit object (`obj_dir` bit 1) winning with a remote frame gives `ans_stb`=1 and its index on `win_idx`. Winning with a data frame gives neither strobe.
- R6: The catch-all never takes a frame that any valid regular object matches.
- R7: The catch-all's effective mask is the format's global mask ANDed with `ca_mask`. A bit under effective mask 1 must equal `ca_pat`. On acceptance, `store_stb`=1 and `win_idx`=NOBJ.
- R8: The catch-all accepts only when `ca_en`=1 and the frame type equals `ca_rtr` (0 = data frames, 1 = remote frames).
- R9: On a catch-all store, `ca_buf` names the buffer written: 0 if both are free, otherwise the free one. If both are full, the most recently written buffer is overwritten and `ca_lost` is set. `ca_full` shows occupancy, with bit i for buffer i.
- R10: A `ca_release` bit i frees buffer i. `ca_lost` clears when the most recently written buffer is released.
- R11: After reset all outputs are 0. A frame offered in ST_IDLE gives exactly one `dec_vld` pulse, two cycles later. Frames offered while a decision is in progress are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_vld | input | 1 | Frame offered for filtering |
| frame_id | input | 29 | Received identifier (standard in bits [10:0]) |
| frame_xtd | input | 1 | 1 = extended format |
| frame_rtr | input | 1 | 1 = remote frame |
| gmask_std | input | 11 | Global mask for standard frames |
| gmask_ext | input | 29 | Global mask for extended frames |
| obj_id | input | NOBJ*29 | Reference identifiers, object k at [k*29 +: 29] |
| obj_xtd | input | NOBJ | Format bit per object |
| obj_dir | input | NOBJ | Direction per object (1 = transmit) |
| obj_val | input | NOBJ | Valid flag per object |
| ca_en | input | 1 | Catch-all enable |
| ca_rtr | input | 1 | Catch-all frame type select |
| ca_mask | input | 29 | Catch-all own mask |
| ca_pat | input | 29 | Catch-all compare pattern |
| ca_release | input | 2 | Free catch-all buffers |
| dec_vld | output | 1 | Decision cycle |
| store_stb | output | 1 | Frame is stored at `win_idx` |
| ans_stb | output | 1 | Remote answer requested by `win_idx` |
| win_idx | output | $clog2(NOBJ+1) | Winning object index |
| ca_buf | output | 1 | Catch-all buffer selected for storing |
| ca_full | output | 2 | Catch-all buffer occupancy |
| ca_lost | output | 1 | Catch-all overwrite occurred |

## Verification
The hardest situation to reach is the overwrite path of the catch-all. It needs both buffers filled by frames that no regular object claims, then a third such frame, and then releases in both orders. The directed tests reach it by sending a run of unmatched standard data frames with no release in between. They then free the older buffer first, which must leave the lost flag set, and the newer buffer second, which must clear it. A second awkward case is a frame that a valid object matches but ignores: a data frame for a transmit object. It must not leak into the catch-all. The table walk checks that buffer occupancy stays at zero afterwards.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;
    localparam int ID_W    = 29;
    localparam int STD_W   = 11;
    localparam int CA_NBUF = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_OBJ_HIT,
        ST_CA_STORE,
        ST_NO_HIT
    } flt_state_e;
endpackage

// File: rtl/can_flt_cmp.sv
module can_flt_cmp
    import can_flt_pkg::*;
#(
    parameter int NOBJ = 4
) (
    input  logic [ID_W-1:0]      fid,
    input  logic                 fxtd,
    input  logic [ID_W-1:0]      fmask,
    input  logic [NOBJ*ID_W-1:0] obj_id,
    input  logic [NOBJ-1:0]      obj_xtd,
    input  logic [NOBJ-1:0]      obj_val,
    output logic [NOBJ-1:0]      hit
);
    // One masked comparator per regular object
    for (genvar g = 0; g < NOBJ; g++) begin : g_cell
        logic [ID_W-1:0] diff;
        assign diff   = (fid ^ obj_id[g*ID_W +: ID_W]) & fmask;
        assign hit[g] = obj_val[g] && (obj_xtd[g] == fxtd) && (diff == '0);
    end
endmodule

// File: rtl/can_flt_prio.sv
module can_flt_prio #(
    parameter int NOBJ = 4,
    localparam int IDXW = $clog2(NOBJ + 1)
) (
    input  logic [NOBJ-1:0] hit,
    output logic            any,
    output logic [IDXW-1:0] idx,
    output logic [NOBJ-1:0] onehot
);
    // Lowest index has priority: scan downward so the last assignment wins
    always_comb begin
        idx    = '0;
        onehot = '0;
        for (int i = NOBJ - 1; i >= 0; i--) begin
            if (hit[i]) begin
                idx       = IDXW'(i);
                onehot    = '0;
                onehot[i] = 1'b1;
            end
        end
        any = |hit;
    end
endmodule

// File: rtl/can_flt_cabuf.sv
module can_flt_cabuf
    import can_flt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [CA_NBUF-1:0] rel,
    output logic               sel,
    output logic [CA_NBUF-1:0] occ,
    output logic               lost
);
    logic newest;

    // Free buffer first, buffer 0 preferred; when full, reuse the newest
    always_comb begin
        if (!occ[0])      sel = 1'b0;
        else if (!occ[1]) sel = 1'b1;
        else              sel = newest;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ    <= '0;
            newest <= 1'b0;
            lost   <= 1'b0;
        end else begin
            for (int i = 0; i < CA_NBUF; i++) begin
                if (wr && (sel == 1'(i))) occ[i] <= 1'b1;
                else if (rel[i])          occ[i] <= 1'b0;
            end
            if (wr) newest <= sel;
            if (wr && (&occ))     lost <= 1'b1;
            else if (rel[newest]) lost <= 1'b0;
        end
    end
endmodule

// File: rtl/can_acc_filter.sv
module can_acc_filter
    import can_flt_pkg::*;
#(
    parameter int NOBJ = 4,
    localparam int IDXW = $clog2(NOBJ + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_vld,
    input  logic [ID_W-1:0]      frame_id,
    input  logic                 frame_xtd,
    input  logic                 frame_rtr,
    input  logic [STD_W-1:0]     gmask_std,
    input  logic [ID_W-1:0]      gmask_ext,
    input  logic [NOBJ*ID_W-1:0] obj_id,
    input  logic [NOBJ-1:0]      obj_xtd,
    input  logic [NOBJ-1:0]      obj_dir,
    input  logic [NOBJ-1:0]      obj_val,
    input  logic                 ca_en,
    input  logic                 ca_rtr,
    input  logic [ID_W-1:0]      ca_mask,
    input  logic [ID_W-1:0]      ca_pat,
    input  logic [CA_NBUF-1:0]   ca_release,
    output logic                 dec_vld,
    output logic                 store_stb,
    output logic                 ans_stb,
    output logic [IDXW-1:0]      win_idx,
    output logic                 ca_buf,
    output logic [CA_NBUF-1:0]   ca_full,
    output logic                 ca_lost
);
    localparam logic [IDXW-1:0] CA_IDX = IDXW'(NOBJ);

    flt_state_e state, state_nx;

    logic [ID_W-1:0] id_q;
    logic            xtd_q;
    logic            rtr_q;
    logic [ID_W-1:0] fmask;
    logic [ID_W-1:0] ca_eff;
    logic [NOBJ-1:0] hit;
    logic            any_hit;
    logic [IDXW-1:0] hit_idx;
    logic [NOBJ-1:0] hit_oh;
    logic [IDXW-1:0] win_q;
    logic [NOBJ-1:0] win_oh_q;
    logic            ca_ok;
    logic            win_dir;
    logic            ca_wr;

    assign fmask  = xtd_q ? gmask_ext : {{(ID_W-STD_W){1'b0}}, gmask_std};
    assign ca_eff = fmask & ca_mask;
    assign ca_ok  = ca_en && (rtr_q == ca_rtr) && (((id_q ^ ca_pat) & ca_eff) == '0);
    assign win_dir = |(win_oh_q & obj_dir);

    can_flt_cmp #(.NOBJ(NOBJ)) u_cmp (
        .fid     (id_q),
        .fxtd    (xtd_q),
        .fmask   (fmask),
        .obj_id  (obj_id),
        .obj_xtd (obj_xtd),
        .obj_val (obj_val),
        .hit     (hit)
    );

    can_flt_prio #(.NOBJ(NOBJ)) u_prio (
        .hit    (hit),
        .any    (any_hit),
        .idx    (hit_idx),
        .onehot (hit_oh)
    );

    can_flt_cabuf u_cabuf (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ca_wr),
        .rel   (ca_release),
        .sel   (ca_buf),
        .occ   (ca_full),
        .lost  (ca_lost)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (frame_vld) state_nx = ST_EVAL;
            ST_EVAL: begin
                if (any_hit)    state_nx = ST_OBJ_HIT;
                else if (ca_ok) state_nx = ST_CA_STORE;
                else            state_nx = ST_NO_HIT;
            end
            ST_OBJ_HIT:  state_nx = ST_IDLE;
            ST_CA_STORE: state_nx = ST_IDLE;
            ST_NO_HIT:   state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // Frame capture and winner capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q     <= '0;
            xtd_q    <= 1'b0;
            rtr_q    <= 1'b0;
            win_q    <= '0;
            win_oh_q <= '0;
        end else begin
            if (state == ST_IDLE && frame_vld) begin
                id_q  <= frame_id;
                xtd_q <= frame_xtd;
                rtr_q <= frame_rtr;
            end
            if (state == ST_EVAL) begin
                win_q    <= hit_idx;
                win_oh_q <= hit_oh;
            end
        end
    end

    // Outputs
    always_comb begin
        dec_vld   = 1'b0;
        store_stb = 1'b0;
        ans_stb   = 1'b0;
        win_idx   = '0;
        ca_wr     = 1'b0;
        unique case (state)
            ST_OBJ_HIT: begin
                dec_vld   = 1'b1;
                win_idx   = win_q;
                store_stb = !win_dir && !rtr_q;
                ans_stb   = win_dir && rtr_q;
            end
            ST_CA_STORE: begin
                dec_vld   = 1'b1;
                store_stb = 1'b1;
                win_idx   = CA_IDX;
                ca_wr     = 1'b1;
            end
            ST_NO_HIT: dec_vld = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/can_acc_filter_chk.sv
module can_acc_filter_chk #(
    parameter int NOBJ = 4,
    localparam int IDXW = $clog2(NOBJ + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            dec_vld,
    input logic            store_stb,
    input logic            ans_stb,
    input logic [IDXW-1:0] win_idx,
    input logic [1:0]      ca_full,
    input logic            ca_lost
);
    localparam logic [IDXW-1:0] CA_IDX = IDXW'(NOBJ);

    // R11
    dec_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |=> !dec_vld);

    // R4
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_stb && ans_stb));

    // R11
    strobe_in_decision_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_stb || ans_stb) |-> dec_vld);

    // R5
    answer_regular_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ans_stb |-> (win_idx < CA_IDX));

    // R9
    lost_needs_full_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ca_lost) |-> $past(store_stb && (win_idx == CA_IDX) && (ca_full == 2'b11)));

    // R9
    fill_needs_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ca_full & ~$past(ca_full))) |-> $past(store_stb && (win_idx == CA_IDX)));
endmodule

bind can_acc_filter can_acc_filter_chk #(.NOBJ(NOBJ)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_vld   (dec_vld),
    .store_stb (store_stb),
    .ans_stb   (ans_stb),
    .win_idx   (win_idx),
    .ca_full   (ca_full),
    .ca_lost   (ca_lost)
);

// File: tb/test_can_acc_filter.sv
`timescale 1ns/1ps
module test_can_acc_filter;
    localparam int NOBJ = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_vld = 1'b0;
    logic [28:0]       frame_id = '0;
    logic              frame_xtd = 1'b0;
    logic              frame_rtr = 1'b0;
    logic [10:0]       gmask_std;
    logic [28:0]       gmask_ext;
    logic [NOBJ*29-1:0] obj_id;
    logic [NOBJ-1:0]   obj_xtd, obj_dir, obj_val;
    logic              ca_en, ca_rtr;
    logic [28:0]       ca_mask, ca_pat;
    logic [1:0]        ca_release = 2'b00;
    logic              dec_vld, store_stb, ans_stb, ca_buf, ca_lost;
    logic [2:0]        win_idx;
    logic [1:0]        ca_full;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    can_acc_filter #(.NOBJ(NOBJ)) i_can_acc_filter (
        .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .frame_id(frame_id),
        .frame_xtd(frame_xtd), .frame_rtr(frame_rtr), .gmask_std(gmask_std),
        .gmask_ext(gmask_ext), .obj_id(obj_id), .obj_xtd(obj_xtd), .obj_dir(obj_dir),
        .obj_val(obj_val), .ca_en(ca_en), .ca_rtr(ca_rtr), .ca_mask(ca_mask),
        .ca_pat(ca_pat), .ca_release(ca_release), .dec_vld(dec_vld),
        .store_stb(store_stb), .ans_stb(ans_stb), .win_idx(win_idx), .ca_buf(ca_buf),
        .ca_full(ca_full), .ca_lost(ca_lost)
    );

    typedef struct packed {
        logic        xtd;
        logic        rtr;
        logic [28:0] id;
        logic [1:0]  kind;   // 0 none, 1 store, 2 answer
        logic [2:0]  idx;
    } vec_t;

    localparam vec_t TBL [9] = '{
        '{1'b0, 1'b0, 29'h123,      2'd1, 3'd0},  // R1 R4 exact std hit
        '{1'b0, 1'b0, 29'h12F,      2'd1, 3'd0},  // R1 low bits masked off
        '{1'b0, 1'b1, 29'h123,      2'd0, 3'd0},  // R3 R4 obj0 beats obj3, ignores remote
        '{1'b0, 1'b1, 29'h235,      2'd2, 3'd1},  // R5 answer
        '{1'b0, 1'b0, 29'h231,      2'd0, 3'd1},  // R5 R6 data to transmit obj ignored
        '{1'b1, 1'b0, 29'h1ABCDEF0, 2'd1, 3'd2},  // R1 extended hit
        '{1'b1, 1'b0, 29'h123,      2'd1, 3'd4},  // R1 R7 format mismatch -> catch-all
        '{1'b1, 1'b1, 29'h1ABCDEF1, 2'd0, 3'd0},  // R8 remote not taken by data catch-all
        '{1'b0, 1'b0, 29'h7FF,      2'd1, 3'd4}   // R7 unmatched std data
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive at a negedge; returns at the negedge of the decision cycle
    task automatic send(input logic x, input logic r, input logic [28:0] id);
        frame_xtd = x; frame_rtr = r; frame_id = id; frame_vld = 1'b1;
        @(negedge clk);
        frame_vld = 1'b0;
        @(negedge clk);
    endtask

    task automatic release_buf(input logic [1:0] m);
        ca_release = m;
        @(negedge clk);
        ca_release = 2'b00;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        gmask_std = 11'h7F0;
        gmask_ext = 29'h1FFFFFFF;
        obj_id    = {29'h120, 29'h1ABCDEF0, 29'h230, 29'h123};
        obj_xtd   = 4'b0100;
        obj_dir   = 4'b1010;
        obj_val   = 4'b1111;
        ca_en = 1'b1; ca_rtr = 1'b0; ca_mask = '0; ca_pat = '0;

        repeat (2) @(negedge clk);
        chk("R11 reset dec_vld", dec_vld, 0);
        chk("R11 reset ca_full", ca_full, 0);
        chk("R11 reset ca_lost", ca_lost, 0);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (TBL[i]) begin
            send(TBL[i].xtd, TBL[i].rtr, TBL[i].id);
            chk($sformatf("R11 vec%0d dec_vld", i), dec_vld, 1);
            chk($sformatf("R4 vec%0d store", i), store_stb, int'(TBL[i].kind == 2'd1));
            chk($sformatf("R5 vec%0d answer", i), ans_stb, int'(TBL[i].kind == 2'd2));
            if (TBL[i].kind != 2'd0)
                chk($sformatf("R3 vec%0d win_idx", i), win_idx, TBL[i].idx);
            @(negedge clk);
            if (TBL[i].kind != 2'd1)
                chk($sformatf("R6 vec%0d ca_full", i), ca_full, 0);
            release_buf(2'b11);
        end

        // R2 invalid object: obj3 takes over
        obj_val = 4'b1110;
        send(1'b0, 1'b1, 29'h123);
        chk("R2 answer by obj3", ans_stb, 1);
        chk("R2 win_idx", win_idx, 3);
        @(negedge clk);
        obj_val = 4'b1111;

        // R9 buffer fill and overwrite
        send(1'b0, 1'b0, 29'h700);
        chk("R9 first buf", ca_buf, 0);
        chk("R7 catch-all idx", win_idx, 4);
        @(negedge clk);
        chk("R9 occ after 1", ca_full, 1);
        send(1'b0, 1'b0, 29'h701);
        chk("R9 second buf", ca_buf, 1);
        @(negedge clk);
        chk("R9 occ after 2", ca_full, 3);
        chk("R9 no lost yet", ca_lost, 0);
        send(1'b0, 1'b0, 29'h702);
        chk("R9 overwrite newest", ca_buf, 1);
        @(negedge clk);
        chk("R9 lost set", ca_lost, 1);

        // R10 releases
        release_buf(2'b01);
        chk("R10 older freed", ca_full, 2);
        chk("R10 lost kept", ca_lost, 1);
        release_buf(2'b10);
        chk("R10 newest freed", ca_full, 0);
        chk("R10 lost cleared", ca_lost, 0);
        send(1'b0, 1'b0, 29'h703); @(negedge clk);
        send(1'b0, 1'b0, 29'h704); @(negedge clk);
        release_buf(2'b01);
        send(1'b0, 1'b0, 29'h705);
        chk("R9 free buffer chosen", ca_buf, 0);
        @(negedge clk);
        chk("R9 no lost with free buf", ca_lost, 0);
        release_buf(2'b11);

        // R8 type select and enable
        ca_rtr = 1'b1;
        send(1'b0, 1'b1, 29'h7FF);
        chk("R8 remote catch-all", store_stb, 1);
        @(negedge clk);
        release_buf(2'b11);
        send(1'b0, 1'b0, 29'h7FF);
        chk("R8 data refused", store_stb, 0);
        @(negedge clk);
        ca_rtr = 1'b0; ca_en = 1'b0;
        send(1'b0, 1'b0, 29'h7FF);
        chk("R8 disabled", store_stb, 0);
        @(negedge clk);
        ca_en = 1'b1;

        // R7 two-level mask
        ca_mask = 29'h00F; ca_pat = 29'h005;
        send(1'b0, 1'b0, 29'h7F6);
        chk("R7 AND to zero accepts", store_stb, 1);
        @(negedge clk);
        release_buf(2'b11);
        gmask_std = 11'h7FF;
        send(1'b0, 1'b0, 29'h7F6);
        chk("R7 pattern mismatch", store_stb, 0);
        @(negedge clk);
        send(1'b0, 1'b0, 29'h7F5);
        chk("R7 pattern match", store_stb, 1);
        @(negedge clk);
        release_buf(2'b11);
        gmask_std = 11'h7F0; ca_mask = '0; ca_pat = '0;

        // R11 frame offered while busy is dropped
        frame_xtd = 1'b0; frame_rtr = 1'b0; frame_id = 29'h123; frame_vld = 1'b1;
        @(negedge clk);
        frame_rtr = 1'b1; frame_id = 29'h230;
        @(negedge clk);
        frame_vld = 1'b0;
        chk("R11 first frame kept", win_idx, 0);
        chk("R11 first frame stored", store_stb, 1);
        @(negedge clk);
        chk("R11 back to idle", dec_vld, 0);
        @(negedge clk);
        chk("R11 busy frame dropped", dec_vld, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule